// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the per-channel completion events of a multi-channel DMA controller and turns them into one interrupt request. Every channel owns a four-bit slot in a 64-bit event space. Three of the slot's bits carry distinct event kinds: half-transfer, package done and queue done. The fourth bit is reserved. The transfer engines pulse an event line for one cycle. The block latches each pulse into a pending bit. Software sets enable bits to choose which pending events may raise the interrupt.

Software reaches the block through a plain 32-bit register strobe port. Two registers hold the enable slots and two hold the pending slots. The lower register of each pair covers the first eight channels and the upper register covers the rest. Software clears pending bits by writing ones to them. The block also presents the full raw pending vector and the enabled pending vector as outputs. The channel count is a parameter of at most 16, and slots beyond it stay inert.

Top module: `dma_irq_aggregator`

## Requirements
- R1: Channel c owns bits 4c+0 (half-transfer), 4c+1 (package done) and 4c+2 (queue done) of the 64-bit `raw_pend`/`masked_pend` space, and bit 4c+3 is always zero. In the registers, channels 0..7 live in the low register of a pair and channels 8..15 in the high one, at bit offset (c mod 8)*4.
- R2: While `rst` is high at a clock edge, all enable and pending bits, `irq`, `masked_pend` and `reg_rdata` become zero.
- R3: A write to offset 0x00 loads the enable bits of channels 0..7 from the data bits at each slot's positions 0..2, and a write to 0x04 does the same for channels 8..15. Reading either offset back returns the stored enables.
- R4: A one-cycle pulse on `evt_half[c]`, `evt_pkg[c]` or `evt_queue[c]` sets the matching pending bit at the next clock edge, whatever the enable bit holds.
- R5: Writing to offset 0x10 (channels 0..7) or 0x14 (channels 8..15) clears each pending bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged. Writing all ones to both offsets clears every pending bit.
- R6: When an event and a clear of the same pending bit fall in the same cycle, the bit is set afterwards.
- R7: `irq` is a register. It is 1 in the cycle after any bit of pending AND enable is 1, and 0 in the cycle after none is.
- R8: A read strobe updates `reg_rdata` at the next edge with the register's value before that edge, and the read has no side effect. Reserved slot bits read as 0. Offsets other than 0x00, 0x04, 0x10 and 0x14 read as 0, and writes to them change nothing.
- R9: Slots of channels at or above `NUM_CH` read as zero in every register and ignore writes.
- R10: `raw_pend` shows the pending state directly. `masked_pend` is a register that shows pending AND enable with the same one-cycle lag as `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_half | input | NUM_CH | Half-transfer event pulse per channel |
| evt_pkg | input | NUM_CH | Package-done event pulse per channel |
| evt_queue | input | NUM_CH | Queue-done event pulse per channel |
| irq | output | 1 | Registered interrupt request |
| raw_pend | output | 64 | Pending bits of all slots |
| masked_pend | output | 64 | Registered pending AND enable |

## Verification
The bench builds the block with `NUM_CH` = 12. With that value the high register pair holds both live slots (channels 8..11) and absent slots (channels 12..15), so a single all-ones write to 0x04 or 0x14 shows the split between them. A behavioural model predicts the enables, the pending bits, the interrupt and the read data. The bench compares them on every clock while directed sequences and a long stretch of random writes, reads and events run, including writes that clear a bit in the same cycle as its event.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int MAX_CH     = 16;
  localparam int SLOT_W     = 4;
  localparam int EVT_PER_CH = 3;
  localparam int CH_PER_REG = 8;
  localparam int REG_W      = 32;
  localparam int SPACE_W    = MAX_CH * SLOT_W;

  // Byte offsets decoded by software; bit positions follow the slot layout
  localparam logic [7:0] OFF_EN_LO = 8'h00;
  localparam logic [7:0] OFF_EN_HI = 8'h04;
  localparam logic [7:0] OFF_PD_LO = 8'h10;
  localparam logic [7:0] OFF_PD_HI = 8'h14;

  typedef struct packed {
    logic en_lo;
    logic en_hi;
    logic pd_lo;
    logic pd_hi;
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode import dma_irq_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.en_lo = (addr == ADDR_W'(OFF_EN_LO));
    sel.en_hi = (addr == ADDR_W'(OFF_EN_HI));
    sel.pd_lo = (addr == ADDR_W'(OFF_PD_LO));
    sel.pd_hi = (addr == ADDR_W'(OFF_PD_HI));
  end
endmodule

// File: rtl/irq_chan_slot.sv
module irq_chan_slot import dma_irq_pkg::*; (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_we,
  input  logic                  w1c_we,
  input  logic [EVT_PER_CH-1:0] wfield,
  input  logic [EVT_PER_CH-1:0] evt,
  output logic [EVT_PER_CH-1:0] en,
  output logic [EVT_PER_CH-1:0] pend
);
  logic [EVT_PER_CH-1:0] clr_mask;

  assign clr_mask = w1c_we ? wfield : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      pend <= '0;
    end else begin
      if (en_we) en <= wfield;
      pend <= (pend & ~clr_mask) | evt;
    end
  end

  AST_EN_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en == '0)); // R2

  for (genvar k = 0; k < EVT_PER_CH; k++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      evt[k] |=> pend[k]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (w1c_we && wfield[k] && !evt[k]) |=> !pend[k]); // R5
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!evt[k] && !(w1c_we && wfield[k])) |=> $stable(pend[k])); // R5
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_vec,
  input  logic [W-1:0] en_vec,
  output logic         irq,
  output logic [W-1:0] masked
);
  logic [W-1:0] live;

  assign live = pend_vec & en_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      masked <= '0;
    end else begin
      irq    <= |live;
      masked <= live;
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(pend_vec & en_vec)) |=> irq); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_vec & en_vec)) |=> !irq); // R7
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((masked & ~$past(pend_vec)) == '0)); // R10
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator import dma_irq_pkg::*; #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_CH-1:0]  evt_half,
  input  logic [NUM_CH-1:0]  evt_pkg,
  input  logic [NUM_CH-1:0]  evt_queue,
  output logic               irq,
  output logic [SPACE_W-1:0] raw_pend,
  output logic [SPACE_W-1:0] masked_pend
);
  localparam int LO_BITS = CH_PER_REG * SLOT_W;

  reg_sel_t           sel;
  logic [SPACE_W-1:0] en_space;
  logic [SPACE_W-1:0] pd_space;
  logic               unused_wbits;

  assign unused_wbits = ^reg_wdata;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  for (genvar c = 0; c < MAX_CH; c++) begin : g_slot
    localparam int LANE = (c % CH_PER_REG) * SLOT_W;
    localparam bit HI   = (c >= CH_PER_REG);
    if (c < NUM_CH) begin : g_live
      logic [EVT_PER_CH-1:0] en_b, pd_b;
      logic en_we, w1c_we;
      assign en_we  = reg_wr && (HI ? sel.en_hi : sel.en_lo);
      assign w1c_we = reg_wr && (HI ? sel.pd_hi : sel.pd_lo);
      irq_chan_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .en_we  (en_we),
        .w1c_we (w1c_we),
        .wfield (reg_wdata[LANE +: EVT_PER_CH]),
        .evt    ({evt_queue[c], evt_pkg[c], evt_half[c]}),
        .en     (en_b),
        .pend   (pd_b)
      );
      assign en_space[c*SLOT_W +: SLOT_W] = {1'b0, en_b};
      assign pd_space[c*SLOT_W +: SLOT_W] = {1'b0, pd_b};
    end else begin : g_absent
      assign en_space[c*SLOT_W +: SLOT_W] = '0;
      assign pd_space[c*SLOT_W +: SLOT_W] = '0;
    end
  end

  irq_combiner #(.W(SPACE_W)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .pend_vec (pd_space),
    .en_vec   (en_space),
    .irq      (irq),
    .masked   (masked_pend)
  );

  assign raw_pend = pd_space;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (1'b1)
        sel.en_lo: reg_rdata <= en_space[LO_BITS-1:0];
        sel.en_hi: reg_rdata <= en_space[SPACE_W-1:LO_BITS];
        sel.pd_lo: reg_rdata <= pd_space[LO_BITS-1:0];
        sel.pd_hi: reg_rdata <= pd_space[SPACE_W-1:LO_BITS];
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (sel == '0)) |=> (reg_rdata == '0)); // R8
  AST_READ_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && (evt_half == '0) && (evt_pkg == '0) && (evt_queue == '0))
      |=> $stable(raw_pend)); // R8
endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
module dma_irq_aggregator_tb_top;
  localparam int  NUM_CH   = 12;
  localparam int  CLK_HALF = 5;
  localparam int  WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_CH-1:0] evt_half = '0, evt_pkg = '0, evt_queue = '0;
  logic        irq;
  logic [63:0] raw_pend, masked_pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk = ~clk;

  dma_irq_aggregator #(.NUM_CH(NUM_CH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_half(evt_half), .evt_pkg(evt_pkg), .evt_queue(evt_queue),
    .irq(irq), .raw_pend(raw_pend), .masked_pend(masked_pend)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_en = '0, m_pend = '0, m_mask = '0;
  logic        m_irq = 1'b0;
  logic [31:0] m_rdata = '0;

  function automatic logic [63:0] valid_bits();
    logic [63:0] v = '0;
    for (int i = 0; i < 64; i++)
      if ((i % 4) != 3 && (i / 4) < NUM_CH) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] event_vec();
    logic [63:0] v = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      v[ch*4+0] = evt_half[ch];
      v[ch*4+1] = evt_pkg[ch];
      v[ch*4+2] = evt_queue[ch];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    logic [63:0] vm, clr;
    vm  = valid_bits();
    clr = '0;
    if (rst) begin
      m_en <= '0; m_pend <= '0; m_mask <= '0; m_irq <= 1'b0; m_rdata <= '0;
    end else begin
      m_irq  <= ((m_pend & m_en) != 0);
      m_mask <= m_pend & m_en;
      if (reg_rd) begin
        case (reg_addr)
          8'h00:   m_rdata <= m_en[31:0];
          8'h04:   m_rdata <= m_en[63:32];
          8'h10:   m_rdata <= m_pend[31:0];
          8'h14:   m_rdata <= m_pend[63:32];
          default: m_rdata <= '0;
        endcase
      end
      if (reg_wr && reg_addr == 8'h00) m_en <= {m_en[63:32], reg_wdata & vm[31:0]};
      if (reg_wr && reg_addr == 8'h04) m_en <= {reg_wdata & vm[63:32], m_en[31:0]};
      if (reg_wr && reg_addr == 8'h10) clr[31:0]  = reg_wdata;
      if (reg_wr && reg_addr == 8'h14) clr[63:32] = reg_wdata;
      m_pend <= ((m_pend & ~clr) | event_vec()) & vm;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 irq", {63'd0, irq}, {63'd0, m_irq});
      chk("R4 raw_pend", raw_pend, m_pend);
      chk("R10 masked_pend", masked_pend, m_mask);
      chk("R8 reg_rdata", {32'd0, reg_rdata}, {32'd0, m_rdata});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rv;

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R2: reset state
    chk("R2 irq after reset", {63'd0, irq}, 64'd0);
    chk("R2 raw_pend after reset", raw_pend, 64'd0);
    chk("R2 rdata after reset", {32'd0, reg_rdata}, 64'd0);
    do_read(8'h04, rv);
    chk("R2 enable high reg after reset", {32'd0, rv}, 64'd0);

    // R3: enables load and read back; reserved bit 3 reads zero
    do_write(8'h00, 32'hFFFF_FFFF);
    do_read(8'h00, rv);
    chk("R3 enable low readback", {32'd0, rv}, 64'h7777_7777);
    // R9: channels 12..15 absent
    do_write(8'h04, 32'hFFFF_FFFF);
    do_read(8'h04, rv);
    chk("R9 enable high readback", {32'd0, rv}, 64'h0000_7777);
    do_write(8'h00, 32'h0);
    do_write(8'h04, 32'h0);

    // R4 / R1: package event on channel 9, enables off
    @(negedge clk); evt_pkg[9] = 1'b1;
    @(negedge clk); evt_pkg[9] = 1'b0;
    chk("R4 pend set without enable", {63'd0, raw_pend[37]}, 64'd1);
    idle(1);
    chk("R7 irq stays low when disabled", {63'd0, irq}, 64'd0);
    do_read(8'h14, rv);
    chk("R1 channel 9 package bit in high pending reg", {32'd0, rv}, 64'h20);

    // R7: enabling raises irq one cycle later
    do_write(8'h04, 32'h20);
    chk("R7 irq not yet", {63'd0, irq}, 64'd0);
    idle(1);
    chk("R7 irq raised", {63'd0, irq}, 64'd1);
    chk("R10 masked bit", masked_pend, 64'h1 << 37);
    // R5: writing zero keeps bit
    do_write(8'h14, 32'h0);
    chk("R5 zero write keeps pend", {63'd0, raw_pend[37]}, 64'd1);
    do_write(8'h14, 32'h20);
    chk("R5 one write clears pend", {63'd0, raw_pend[37]}, 64'd0);
    idle(1);
    chk("R7 irq dropped", {63'd0, irq}, 64'd0);

    // R6: event and clear in the same cycle
    @(negedge clk);
    evt_half[3] = 1'b1; reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h0000_1000;
    @(negedge clk);
    evt_half[3] = 1'b0; reg_wr = 1'b0;
    chk("R6 event wins over clear", {63'd0, raw_pend[12]}, 64'd1);

    // R5: all-ones clear
    @(negedge clk); evt_queue = '1; evt_half = '1;
    @(negedge clk); evt_queue = '0; evt_half = '0;
    chk("R1 queue and half bits of all live slots", raw_pend, 64'h0000_5555_5555_5555);
    do_write(8'h10, 32'hFFFF_FFFF);
    do_write(8'h14, 32'hFFFF_FFFF);
    chk("R5 all ones clears all", raw_pend, 64'd0);

    // R8: unmapped access
    do_write(8'h00, 32'h0000_0044);
    do_write(8'h30, 32'hFFFF_FFFF);
    do_read(8'h00, rv);
    chk("R8 unmapped write ignored", {32'd0, rv}, 64'h44);
    do_read(8'h08, rv);
    chk("R8 unmapped read zero", {32'd0, rv}, 64'd0);

    // random traffic, checked every clock by the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_rd    = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 4))
        0: reg_addr = 8'h00;
        1: reg_addr = 8'h04;
        2: reg_addr = 8'h10;
        3: reg_addr = 8'h14;
        default: reg_addr = 8'h08;
      endcase
      reg_wdata = $urandom;
      evt_half  = ($urandom_range(0, 3) == 0) ? NUM_CH'($urandom) : '0;
      evt_pkg   = ($urandom_range(0, 3) == 0) ? NUM_CH'($urandom) : '0;
      evt_queue = ($urandom_range(0, 3) == 0) ? NUM_CH'($urandom) : '0;
    end
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; evt_half = '0; evt_pkg = '0; evt_queue = '0;
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule